// File: doc/BRIEF.md
# Cipher Start and Status Controller

This block decides when an external block-cipher datapath is launched and records when that datapath, or a separate Galois-field multiplier, reports that its work is done. Software reaches it through a 32-bit write port. The datapath sees only a one-cycle launch pulse going out and a one-cycle completion pulse coming back. The rounds, the key schedule and any data movement stay outside this block.

There are two launch policies. In the software-triggered policy, only an explicit start command launches the datapath. In the self-triggered policy, the block counts input words and launches as soon as a full block has arrived. The block also holds two message-framing levels: one marks the next block as the first of a message, and one marks the end of a message. It can also issue a trigger pulse to the Galois-field multiplier. Two sticky completion flags stay set until software clears them by writing ones.

Top module: `cipher_start_ctrl`

## Requirements
- R1: After reset, `launch_o`, `busy_o`, `flags_o`, `first_blk_o`, `last_msg_o` and `gf_go_o` are all low, and the launch policy is software-triggered.
- R2: Register map by `wr_addr_i`: 0 = configuration, 1 = command, 2 = flag clear, 3 = input data word, 4 = input pointer reset. With configuration bit 0 = 0 (software-triggered), a command write with bit 0 set while idle raises `launch_o` for exactly the one cycle after the write. Input data writes never launch in this policy.
- R3: With configuration bit 0 = 1 (self-triggered), the write that completes a block of BLOCK_W/DATA_W input words raises `launch_o` in the following cycle. The command start bit has no effect in this policy.
- R4: The input word count returns to zero after every accepted launch, after every completed block, and after any write to the pointer-reset address, so the next block needs a full set of words again.
- R5: `busy_o` rises together with `launch_o` and stays high until the cycle after `cipher_done_i` is sampled. A launch request that arrives while busy is dropped.
- R6: `flags_o[0]` is set by `cipher_done_i` and `flags_o[1]` by `gf_done_i`. Both stay set until cleared.
- R7: A write to the flag-clear address clears each flag whose bit is 1 in the written data and leaves the others unchanged.
- R8: If a completion pulse and a clearing write to the same flag fall in the same cycle, the flag ends up set.
- R9: A command write loads bit 1 into `first_blk_o` and bit 2 into `last_msg_o`. Each level holds until the next command write.
- R10: A command write with bit 3 set raises `gf_go_o` for the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | DATA_W | Register write data |
| cipher_done_i | input | 1 | Completion pulse from the cipher datapath |
| gf_done_i | input | 1 | Completion pulse from the Galois-field multiplier |
| launch_o | output | 1 | One-cycle start pulse to the cipher datapath |
| busy_o | output | 1 | Datapath operation in flight |
| flags_o | output | 2 | Sticky completion flags: bit 0 cipher, bit 1 Galois-field |
| first_blk_o | output | 1 | Next block starts a new message |
| last_msg_o | output | 1 | End-of-message marker |
| gf_go_o | output | 1 | One-cycle trigger to the Galois-field multiplier |

## Verification
The bench uses the default parameters: 32-bit words and a 128-bit block, so a block is four data writes. With that short block, random traffic regularly reaches the fourth-word boundary in both launch policies. It also often lands data writes while a launch is in flight, and pointer resets in the middle of a block. Completion pulses are issued only while the model is busy, and they coincide with random flag-clear writes often enough to exercise the same-cycle priority rule.

// File: rtl/cstart_pkg.sv
package cstart_pkg;

    localparam int unsigned REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] ADDR_CFG     = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_CMD     = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_FLAGCLR = 3'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_DATA    = 3'd3;
    localparam logic [REG_ADDR_W-1:0] ADDR_PTRCLR  = 3'd4;

    localparam int unsigned CMD_START_BIT = 0;
    localparam int unsigned CMD_FIRST_BIT = 1;
    localparam int unsigned CMD_LAST_BIT  = 2;
    localparam int unsigned CMD_GF_BIT    = 3;

    localparam int unsigned FLAG_CIPHER = 0;
    localparam int unsigned FLAG_GF     = 1;
    localparam int unsigned NUM_FLAGS   = 2;

    typedef enum logic {
        LAUNCH_SW   = 1'b0,
        LAUNCH_AUTO = 1'b1
    } launch_mode_e;

    typedef struct packed {
        launch_mode_e mode;
        logic         first_blk;
        logic         last_msg;
        logic         gf_go;
    } ctrl_state_t;

endpackage

// File: rtl/cstart_word_cnt.sv
module cstart_word_cnt #(
    parameter int unsigned WORDS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_wr_i,
    input  logic clear_i,
    output logic block_full_o
);
    localparam int unsigned CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign block_full_o = word_wr_i && (st_q.cnt == LAST_IDX);

    always_comb begin
        st_d = st_q;
        if (clear_i || block_full_o) begin
            st_d.cnt = '0;
        end else if (word_wr_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_IDX);

    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> st_q.cnt == '0);

endmodule

// File: rtl/cstart_sticky_flag.sv
module cstart_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R8
    done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(set_i));

endmodule

// File: rtl/cstart_launch.sv
module cstart_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic done_i,
    output logic accept_o,
    output logic launch_o,
    output logic busy_o
);
    typedef struct packed {
        logic busy;
        logic launch;
    } launch_state_t;

    launch_state_t st_d, st_q;

    assign accept_o = req_i && !st_q.busy;

    always_comb begin
        st_d        = st_q;
        st_d.launch = accept_o;
        if (accept_o) begin
            st_d.busy = 1'b1;
        end else if (done_i) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign launch_o = st_q.launch;
    assign busy_o   = st_q.busy;

    // R5
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> (busy_o && !$past(busy_o)));

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_i));

endmodule

// File: rtl/cipher_start_ctrl.sv
module cipher_start_ctrl
    import cstart_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned BLOCK_W = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic                  cipher_done_i,
    input  logic                  gf_done_i,
    output logic                  launch_o,
    output logic                  busy_o,
    output logic [NUM_FLAGS-1:0]  flags_o,
    output logic                  first_blk_o,
    output logic                  last_msg_o,
    output logic                  gf_go_o
);
    localparam int unsigned WORDS = BLOCK_W / DATA_W;

    logic wr_cfg, wr_cmd, wr_flagclr, wr_data, wr_ptrclr;
    logic sw_req, auto_req, accept, block_full;
    logic unused_hi;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr;

    ctrl_state_t st_d, st_q;

    assign wr_cfg     = wr_en_i && (wr_addr_i == ADDR_CFG);
    assign wr_cmd     = wr_en_i && (wr_addr_i == ADDR_CMD);
    assign wr_flagclr = wr_en_i && (wr_addr_i == ADDR_FLAGCLR);
    assign wr_data    = wr_en_i && (wr_addr_i == ADDR_DATA);
    assign wr_ptrclr  = wr_en_i && (wr_addr_i == ADDR_PTRCLR);
    assign unused_hi  = ^wr_data_i[DATA_W-1:4];

    assign sw_req   = wr_cmd && wr_data_i[CMD_START_BIT] && (st_q.mode == LAUNCH_SW);
    assign auto_req = block_full && (st_q.mode == LAUNCH_AUTO);

    always_comb begin
        st_d       = st_q;
        st_d.gf_go = wr_cmd && wr_data_i[CMD_GF_BIT];
        if (wr_cfg) begin
            st_d.mode = launch_mode_e'(wr_data_i[0]);
        end
        if (wr_cmd) begin
            st_d.first_blk = wr_data_i[CMD_FIRST_BIT];
            st_d.last_msg  = wr_data_i[CMD_LAST_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: LAUNCH_SW, first_blk: 1'b0, last_msg: 1'b0, gf_go: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    cstart_word_cnt #(
        .WORDS(WORDS)
    ) i_word_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_wr_i   (wr_data),
        .clear_i     (wr_ptrclr || accept),
        .block_full_o(block_full)
    );

    cstart_launch i_launch (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (sw_req || auto_req),
        .done_i  (cipher_done_i),
        .accept_o(accept),
        .launch_o(launch_o),
        .busy_o  (busy_o)
    );

    assign flag_set[FLAG_CIPHER] = cipher_done_i;
    assign flag_set[FLAG_GF]     = gf_done_i;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        assign flag_clr[g] = wr_flagclr && wr_data_i[g];
        cstart_sticky_flag i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[g]),
            .clr_i (flag_clr[g]),
            .flag_o(flags_o[g])
        );
    end

    assign first_blk_o = st_q.first_blk;
    assign last_msg_o  = st_q.last_msg;
    assign gf_go_o     = st_q.gf_go;

    // R10
    gf_go_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gf_go_o |-> $past(wr_en_i && wr_addr_i == ADDR_CMD));

    // R2
    sw_no_data_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_o && $past(st_q.mode == LAUNCH_SW)) |-> $past(wr_addr_i == ADDR_CMD));

endmodule

// File: tb/test_cipher_start_ctrl.sv
module test_cipher_start_ctrl;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic cdone = 1'b0, gdone = 1'b0;
    logic launch, busy, first_blk, last_msg, gf_go;
    logic [1:0] flags;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit m_auto, m_busy, m_launch, m_f0, m_f1, m_first, m_last, m_gf;
    int m_cnt;

    always #5 clk = ~clk;

    cipher_start_ctrl #(.DATA_W(DW), .BLOCK_W(128)) i_cipher_start_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .cipher_done_i(cdone), .gf_done_i(gdone),
        .launch_o(launch), .busy_o(busy), .flags_o(flags),
        .first_blk_o(first_blk), .last_msg_o(last_msg), .gf_go_o(gf_go));

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, m_auto ? "R3 launch" : "R2 launch", 32'(launch), 32'(m_launch));
        chk(tag, "R5 busy", 32'(busy), 32'(m_busy));
        chk(tag, "R6 cipher flag", 32'(flags[0]), 32'(m_f0));
        chk(tag, "R6 gf flag", 32'(flags[1]), 32'(m_f1));
        chk(tag, "R9 first", 32'(first_blk), 32'(m_first));
        chk(tag, "R9 last", 32'(last_msg), 32'(m_last));
        chk(tag, "R10 gf_go", 32'(gf_go), 32'(m_gf));
    endtask

    task automatic apply(bit wr, logic [2:0] a, logic [31:0] d, bit cd, bit gd, string tag);
        bit data_wr, full, req, acc;
        wr_en = wr; wr_addr = a; wr_data = d; cdone = cd; gdone = gd;
        data_wr = wr && a == 3'd3;
        full    = data_wr && m_cnt == 3;
        req     = (wr && a == 3'd1 && d[0] && !m_auto) || (m_auto && full);
        acc     = req && !m_busy;
        @(posedge clk);
        m_launch = acc;
        if ((wr && a == 3'd4) || acc || full) m_cnt = 0;
        else if (data_wr) m_cnt++;
        if (acc) m_busy = 1'b1; else if (cd) m_busy = 1'b0;
        if (cd) m_f0 = 1'b1; else if (wr && a == 3'd2 && d[0]) m_f0 = 1'b0;
        if (gd) m_f1 = 1'b1; else if (wr && a == 3'd2 && d[1]) m_f1 = 1'b0;
        if (wr && a == 3'd0) m_auto = d[0];
        if (wr && a == 3'd1) begin m_first = d[1]; m_last = d[2]; end
        m_gf = wr && a == 3'd1 && d[3];
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(string tag);
        apply(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        m_auto = 0; m_busy = 0; m_launch = 0; m_f0 = 0; m_f1 = 0;
        m_first = 0; m_last = 0; m_gf = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1 reset");

        // R2 manual start, then completion
        apply(1, 3'd1, 32'h1, 0, 0, "R2");
        idle("R2");
        apply(0, 3'd0, 0, 1, 0, "R2");
        // R2 four data words never launch in manual mode
        for (int i = 0; i < 4; i++) apply(1, 3'd3, 32'(i), 0, 0, "R2");
        idle("R2");
        // R7 clear only selected bits
        apply(0, 3'd0, 0, 0, 1, "R7");
        apply(1, 3'd2, 32'h2, 0, 0, "R7");
        apply(1, 3'd2, 32'h1, 0, 0, "R7");
        // R3 / R4 auto mode with pointer reset mid-block
        apply(1, 3'd0, 32'h1, 0, 0, "R3");
        apply(1, 3'd1, 32'h1, 0, 0, "R3");
        for (int i = 0; i < 3; i++) apply(1, 3'd3, 32'(i), 0, 0, "R4");
        apply(1, 3'd4, 0, 0, 0, "R4");
        for (int i = 0; i < 3; i++) apply(1, 3'd3, 32'(i), 0, 0, "R4");
        apply(1, 3'd3, 32'h9, 0, 0, "R3");
        // R5 full block while busy is dropped
        for (int i = 0; i < 4; i++) apply(1, 3'd3, 32'(i), 0, 0, "R5");
        idle("R5");
        // R8 done and clear together, flag stays set
        apply(1, 3'd2, 32'h3, 1, 0, "R8");
        for (int i = 0; i < 4; i++) apply(1, 3'd3, 32'(i), 0, 0, "R3");
        apply(1, 3'd2, 32'h1, 1, 0, "R8");
        apply(1, 3'd2, 32'h2, 0, 1, "R8");
        // R9 / R10 command fields
        apply(1, 3'd1, 32'hE, 0, 0, "R9");
        apply(1, 3'd1, 32'h2, 0, 0, "R10");
        apply(1, 3'd1, 32'h4, 0, 0, "R9");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            bit wr, cd, gd;
            logic [2:0] a;
            logic [31:0] d;
            wr = ($urandom % 10) < 7;
            a  = 3'($urandom % 5);
            if (a == 3'd0 && ($urandom % 3) != 0) a = 3'd3;
            d  = $urandom;
            cd = m_busy && (($urandom % 4) == 0);
            gd = ($urandom % 8) == 0;
            apply(wr, a, d, cd, gd, "random");
        end
        idle("R1 end");

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule